// File: doc/BRIEF.md
# Strobed Parallel Port Controller

This block is a byte-wide peripheral that sits on a simple host bus and gives the host three 8-bit ports, A, B and C, plus one write-only control register. A mode word written to the control register sets each group's operating style and line directions. In the plain style a port is a latched output or a directly read input. In the strobed style a port trades data with an external device under a single request/acknowledge handshake, and some port C lines carry the handshake and interrupt signals.

The host bus is synchronous to `clk`. Every cycle in which `cs` is high together with `wr` or `rd` is one access. Read data is combinational from the current state. Any side effect of a read, such as clearing a buffer-full flag, takes place at the clock edge that ends the access. On the peripheral side each port has separate input, output and output-enable vectors. The external strobe and acknowledge lines pass through a two-flop synchroniser before edge detection, so a pin change acts on internal state at the third rising edge after it.

Register addresses: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. A control register read returns zero.

Top module: `strobe_port`

## Requirements
- R1: After reset all three ports are plain-style inputs, every output-enable bit is 0, and a read of port A returns the level on `pa_in`.
- R2: A control write with bit 7 = 0 is a single-bit command on the port C latch. Bits 3..1 select the bit and bit 0 gives the new value (1 sets, 0 clears). Bits 6..4 have no effect.
- R3: A control write with bit 7 = 1 is a mode word, where a direction bit of 1 means input. Bit 4 sets port A's direction, bit 1 sets port B's, bit 3 sets port C bits 7..4 and bit 0 sets port C bits 3..0. In the plain style an output port drives its latch with every enable bit set. An input port reads its pins. The two port C halves are independent of each other.
- R4: A mode-word write clears the A, B and C output latches, both buffer-full flags, both interrupt flags and both interrupt-enable bits. Buffer-full outputs return to their inactive level.
- R5: Group A mode is taken from bits 6..5: 01 selects the strobed style. Group B mode is bit 2: 1 selects the strobed style. A group A value of 1x gives plain-style behaviour.
- R6: With port A strobed as an input, a low level on strobe line PC4 loads `pa_in` into the input latch and drives buffer-full on PC5 high. A later port A read returns the latched byte even after the pins change.
- R7: With port A strobed as an input, the interrupt on PC3 goes high after PC4 returns high, but only if port A's interrupt-enable bit is set. That bit is port C bit 4 and is set by a single-bit command. A port A read clears both buffer-full and the interrupt.
- R8: With port A strobed as an output, a port A write drives the active-low buffer-full line PC7 low and clears the interrupt. A low on acknowledge line PC6 returns PC7 high. When PC6 rises, the interrupt on PC3 goes high if the enable bit is set; that bit is port C bit 6.
- R9: With port B strobed, PC0 carries the interrupt, PC1 carries buffer-full, and PC2 is the strobe or acknowledge input. PC1 is active high for input and active low for output. Port B's enable bit is port C bit 2. Handshake inputs have output-enable 0 and handshake outputs have output-enable 1.
- R10: A port C read returns status on the handshake positions and I/O values elsewhere. The status positions are: interrupt flags at bits 3 and 0; enable bits at bit 4 (A input), bit 6 (A output) and bit 2 (B); buffer-full at bits 5, 7 and 1, each at its pin polarity. Other bits return the pin for an input half and the latch for an output half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, zero outside reads |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels, including strobe and acknowledge |
| pc_out | output | 8 | Port C drive values, including handshake outputs |
| pc_oe | output | 8 | Port C output enables |

## Verification
A wrong mode decode shows up at once in the output-enable vectors, one cycle after the mode write. A stuck or lost buffer-full flag shows on PC5, PC7 or PC1 three edges after a strobe edge. It also shows in the next port C status read. A wrong interrupt-enable bit stays hidden until a handshake completes; then the interrupt line fails to rise, or rises when it should not. A corrupted input latch is seen only at the next port read, so the bench changes the pins before that read.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

  localparam logic [1:0] ADDR_A    = 2'd0;
  localparam logic [1:0] ADDR_B    = 2'd1;
  localparam logic [1:0] ADDR_C    = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } port_cfg_t;

  localparam port_cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                      b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic port_cfg_t decode_mode(input logic [7:0] w);
    port_cfg_t c;
    c.a_mode = w[6:5];
    c.a_in   = w[4];
    c.cu_in  = w[3];
    c.b_mode = w[2];
    c.b_in   = w[1];
    c.cl_in  = w[0];
    return c;
  endfunction

  function automatic logic [7:0] apply_bit_cmd(input logic [7:0] cur, input logic [7:0] cmd);
    logic [7:0] nxt;
    nxt = cur;
    nxt[cmd[3:1]] = cmd[0];
    return nxt;
  endfunction

endpackage

// File: rtl/strobe_port_sync.sv
module strobe_port_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
      prev <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/strobe_port_chan.sv
module strobe_port_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          dir_in,
  input  logic          stb_low,
  input  logic          stb_rise,
  input  logic          stb_fall,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic          inte,
  input  logic [DW-1:0] pin_in,
  output logic          full,
  output logic          intr,
  output logic [DW-1:0] cap
);
  logic req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      req  <= 1'b0;
      cap  <= '0;
    end else if (clr) begin
      full <= 1'b0;
      req  <= 1'b0;
      cap  <= '0;
    end else if (en) begin
      if (dir_in) begin
        if (rd_hit) begin
          full <= 1'b0;
          req  <= 1'b0;
        end
        if (stb_low) begin
          full <= 1'b1;
          cap  <= pin_in;
        end
        if (stb_rise && inte) req <= 1'b1;
      end else begin
        if (stb_fall) full <= 1'b0;
        if (stb_rise && inte) req <= 1'b1;
        if (wr_hit) begin
          full <= 1'b1;
          req  <= 1'b0;
        end
      end
    end
  end

  assign intr = req & inte;
endmodule

// File: rtl/strobe_port.sv
module strobe_port
  import strobe_port_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int HALF = DW / 2;

  port_cfg_t     cfg;
  logic [DW-1:0] a_lat, b_lat, c_lat;
  logic          inte_a, inte_b;

  // named bus events
  logic host_wr, host_rd, mode_set, bit_cmd;
  logic wr_a, wr_b, wr_c, rd_a, rd_b;
  assign host_wr  = cs & wr;
  assign host_rd  = cs & rd;
  assign mode_set = host_wr && addr == ADDR_CTRL && wdata[7];
  assign bit_cmd  = host_wr && addr == ADDR_CTRL && !wdata[7];
  assign wr_a     = host_wr && addr == ADDR_A;
  assign wr_b     = host_wr && addr == ADDR_B;
  assign wr_c     = host_wr && addr == ADDR_C;
  assign rd_a     = host_rd && addr == ADDR_A;
  assign rd_b     = host_rd && addr == ADDR_B;

  logic a_strobed, b_strobed, a_in_strobed, a_out_strobed;
  assign a_strobed     = cfg.a_mode == 2'b01;
  assign b_strobed     = cfg.b_mode;
  assign a_in_strobed  = a_strobed & cfg.a_in;
  assign a_out_strobed = a_strobed & ~cfg.a_in;

  // handshake input synchroniser
  logic [DW-1:0] c_lvl, c_rise, c_fall;
  strobe_port_sync #(.N(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pc_in), .lvl(c_lvl), .rise(c_rise), .fall(c_fall)
  );

  logic a_stb_low, a_stb_rise, a_stb_fall;
  assign a_stb_low  = cfg.a_in ? ~c_lvl[4] : ~c_lvl[6];
  assign a_stb_rise = cfg.a_in ? c_rise[4] : c_rise[6];
  assign a_stb_fall = cfg.a_in ? c_fall[4] : c_fall[6];

  logic          full_a, intr_a, full_b, intr_b;
  logic [DW-1:0] cap_a, cap_b;

  strobe_port_chan #(.DW(DW)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .en(a_strobed), .dir_in(cfg.a_in),
    .stb_low(a_stb_low), .stb_rise(a_stb_rise), .stb_fall(a_stb_fall),
    .wr_hit(wr_a), .rd_hit(rd_a), .inte(inte_a), .pin_in(pa_in),
    .full(full_a), .intr(intr_a), .cap(cap_a)
  );

  strobe_port_chan #(.DW(DW)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .en(b_strobed), .dir_in(cfg.b_in),
    .stb_low(~c_lvl[2]), .stb_rise(c_rise[2]), .stb_fall(c_fall[2]),
    .wr_hit(wr_b), .rd_hit(rd_b), .inte(inte_b), .pin_in(pb_in),
    .full(full_b), .intr(intr_b), .cap(cap_b)
  );

  // configuration, latches and enable bits
  logic [2:0] inte_a_pos;
  assign inte_a_pos = cfg.a_in ? 3'd4 : 3'd6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= CFG_RESET;
      a_lat  <= '0;
      b_lat  <= '0;
      c_lat  <= '0;
      inte_a <= 1'b0;
      inte_b <= 1'b0;
    end else if (mode_set) begin
      cfg    <= decode_mode(wdata);
      a_lat  <= '0;
      b_lat  <= '0;
      c_lat  <= '0;
      inte_a <= 1'b0;
      inte_b <= 1'b0;
    end else begin
      if (wr_a) a_lat <= wdata;
      if (wr_b) b_lat <= wdata;
      if (wr_c) c_lat <= wdata;
      if (bit_cmd) begin
        c_lat <= apply_bit_cmd(c_lat, wdata);
        if (a_strobed && wdata[3:1] == inte_a_pos) inte_a <= wdata[0];
        if (b_strobed && wdata[3:1] == 3'd2)       inte_b <= wdata[0];
      end
    end
  end

  // port C line ownership
  logic [DW-1:0] hs_own, hs_drv, hs_val, hs_st, gen_oe, c_rd;
  always_comb begin
    hs_own = '0;
    hs_drv = '0;
    hs_val = '0;
    hs_st  = '0;
    if (a_strobed) begin
      hs_own[3] = 1'b1; hs_drv[3] = 1'b1; hs_val[3] = intr_a; hs_st[3] = intr_a;
      if (cfg.a_in) begin
        hs_own[4] = 1'b1; hs_st[4] = inte_a;
        hs_own[5] = 1'b1; hs_drv[5] = 1'b1; hs_val[5] = full_a; hs_st[5] = full_a;
      end else begin
        hs_own[6] = 1'b1; hs_st[6] = inte_a;
        hs_own[7] = 1'b1; hs_drv[7] = 1'b1; hs_val[7] = ~full_a; hs_st[7] = ~full_a;
      end
    end
    if (b_strobed) begin
      hs_own[2:0] = 3'b111;
      hs_drv[1:0] = 2'b11;
      hs_val[0]   = intr_b;
      hs_val[1]   = cfg.b_in ? full_b : ~full_b;
      hs_st[0]    = hs_val[0];
      hs_st[1]    = hs_val[1];
      hs_st[2]    = inte_b;
    end
  end

  assign gen_oe = {{(DW-HALF){~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
  assign pc_oe  = (hs_own & hs_drv) | (~hs_own & gen_oe);
  assign pc_out = (hs_own & hs_val) | (~hs_own & c_lat);
  assign c_rd   = (hs_own & hs_st) | (~hs_own & ((gen_oe & c_lat) | (~gen_oe & pc_in)));

  assign pa_out = a_lat;
  assign pa_oe  = {DW{~cfg.a_in}};
  assign pb_out = b_lat;
  assign pb_oe  = {DW{~cfg.b_in}};

  always_comb begin
    rdata = '0;
    if (host_rd) begin
      unique case (addr)
        ADDR_A:  rdata = a_in_strobed ? cap_a : (cfg.a_in ? pa_in : a_lat);
        ADDR_B:  rdata = (b_strobed && cfg.b_in) ? cap_b : (cfg.b_in ? pb_in : b_lat);
        ADDR_C:  rdata = c_rd;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pc_out,
  input logic [DW-1:0] c_lat,
  input logic          inte_a,
  input logic          inte_b,
  input logic          full_a,
  input logic          full_b,
  input logic          a_in_strobed,
  input logic          a_out_strobed,
  input logic          a_stb_low,
  input logic          a_stb_rise
);
  assert_bit_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && !wdata[7])
    |=> (((c_lat >> $past(wdata[3:1])) & 8'h01) == {7'b0, $past(wdata[0])}));

  assert_oe_uniform_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe == '0) || (pa_oe == '1));

  assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd3 && wdata[7])
    |=> (pa_out == '0 && !inte_a && !inte_b && !full_a && !full_b));

  assert_ibf_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in_strobed && a_stb_low && !(cs && wr && addr == 2'd3 && wdata[7]))
    |=> full_a);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in_strobed && cs && rd && addr == 2'd0 && !a_stb_low && !a_stb_rise)
    |=> (!full_a && !pc_out[3]));

  assert_obf_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_out_strobed && cs && wr && addr == 2'd0)
    |=> !pc_out[7]);
endmodule

bind strobe_port strobe_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .pa_out(pa_out), .pa_oe(pa_oe), .pc_out(pc_out), .c_lat(c_lat),
  .inte_a(inte_a), .inte_b(inte_b), .full_a(full_a), .full_b(full_b),
  .a_in_strobed(a_in_strobed), .a_out_strobed(a_out_strobed),
  .a_stb_low(a_stb_low), .a_stb_rise(a_stb_rise)
);

// File: tb/strobe_port_tb.sv
module strobe_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int checks = 0;
  int errors = 0;

  string      q_req [$];
  logic [7:0] q_exp [$];

  always #2 clk = ~clk;

  strobe_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    if (cs && rd) begin
      string      r;
      logic [7:0] e;
      if (q_exp.size() == 0) begin
        r = "none";
        e = 8'hxx;
      end else begin
        r = q_req.pop_front();
        e = q_exp.pop_front();
      end
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s read addr %0d: actual=%02h expected=%02h", r, addr, rdata, e);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, input logic [7:0] exp, input string req);
    q_req.push_back(req);
    q_exp.push_back(exp);
    @(posedge clk); #1;
    cs = 1'b1; rd = 1'b1; addr = a;
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    pa_in = 8'h6C;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    settle();
    chk("R1", "pa_oe", pa_oe, 8'h00);
    chk("R1", "pb_oe", pb_oe, 8'h00);
    chk("R1", "pc_oe", pc_oe, 8'h00);
    host_read(2'd0, 8'h6C, "R1");

    // R3 all outputs, plain style
    host_write(2'd3, 8'h80);
    settle();
    chk("R3", "pa_oe", pa_oe, 8'hFF);
    chk("R3", "pb_oe", pb_oe, 8'hFF);
    chk("R3", "pc_oe", pc_oe, 8'hFF);
    host_write(2'd0, 8'h5A);
    settle();
    chk("R3", "pa_out", pa_out, 8'h5A);

    // R2 single-bit commands
    host_write(2'd2, 8'h00);
    host_write(2'd3, 8'h0B);
    settle();
    chk("R2", "set bit5", pc_out, 8'h20);
    host_write(2'd3, 8'h75);
    settle();
    chk("R2", "set bit2, upper bits ignored", pc_out, 8'h24);
    host_write(2'd3, 8'h0A);
    settle();
    chk("R2", "clear bit5", pc_out, 8'h04);

    // R3 independent port C halves
    host_write(2'd3, 8'h88);
    host_write(2'd3, 8'h05);
    settle();
    chk("R3", "pc_oe halves", pc_oe, 8'h0F);
    pc_in = 8'hA3;
    host_read(2'd2, 8'hA4, "R3");
    pc_in = 8'hFF;

    // R4 mode word clears the output latch
    host_write(2'd0, 8'h5A);
    host_write(2'd3, 8'h80);
    settle();
    chk("R4", "pa_out cleared", pa_out, 8'h00);
    chk("R4", "pc_out cleared", pc_out, 8'h00);

    // R5 group A mode 2 acts as plain style
    host_write(2'd3, 8'hC0);
    host_write(2'd0, 8'h33);
    settle();
    chk("R5", "pa_out", pa_out, 8'h33);
    chk("R5", "pc_oe no handshake", pc_oe, 8'hFF);
    host_read(2'd0, 8'h33, "R5");

    // R6/R7 strobed input on port A
    host_write(2'd3, 8'hB0);
    host_write(2'd3, 8'h09);
    pa_in = 8'h96;
    pc_in[4] = 1'b0;
    idle(5);
    settle();
    chk("R6", "IBF on PC5", {7'b0, pc_out[5]}, 8'h01);
    chk("R6", "PC5 driven, PC4 not", {6'b0, pc_oe[5], pc_oe[4]}, 8'h02);
    chk("R7", "no INTR while strobe low", {7'b0, pc_out[3]}, 8'h00);
    pc_in[4] = 1'b1;
    idle(5);
    pa_in = 8'h22;
    settle();
    chk("R7", "INTR after strobe high", {7'b0, pc_out[3]}, 8'h01);
    host_read(2'd2, 8'h38, "R10");
    host_read(2'd0, 8'h96, "R6");
    settle();
    chk("R7", "read clears IBF", {7'b0, pc_out[5]}, 8'h00);
    chk("R7", "read clears INTR", {7'b0, pc_out[3]}, 8'h00);
    host_write(2'd3, 8'h08);
    pc_in[4] = 1'b0;
    idle(5);
    pc_in[4] = 1'b1;
    idle(5);
    settle();
    chk("R7", "IBF with enable off", {7'b0, pc_out[5]}, 8'h01);
    chk("R7", "no INTR with enable off", {7'b0, pc_out[3]}, 8'h00);
    host_read(2'd0, 8'h22, "R6");

    // R8 strobed output on port A
    host_write(2'd3, 8'hA0);
    settle();
    chk("R4", "OBF idle high", {7'b0, pc_out[7]}, 8'h01);
    host_write(2'd3, 8'h0D);
    host_write(2'd0, 8'hC3);
    settle();
    chk("R8", "OBF low after write", {7'b0, pc_out[7]}, 8'h00);
    chk("R8", "pa_out", pa_out, 8'hC3);
    pc_in[6] = 1'b0;
    idle(5);
    settle();
    chk("R8", "OBF high after ACK", {7'b0, pc_out[7]}, 8'h01);
    chk("R8", "no INTR while ACK low", {7'b0, pc_out[3]}, 8'h00);
    pc_in[6] = 1'b1;
    idle(5);
    settle();
    chk("R8", "INTR after ACK high", {7'b0, pc_out[3]}, 8'h01);
    host_read(2'd2, 8'hC8, "R10");
    host_write(2'd0, 8'h11);
    settle();
    chk("R8", "write clears INTR", {7'b0, pc_out[3]}, 8'h00);

    // R9 strobed input on port B
    host_write(2'd3, 8'h86);
    host_write(2'd3, 8'h05);
    settle();
    chk("R9", "pc_oe B strobed", pc_oe, 8'hFB);
    pb_in = 8'h4E;
    pc_in[2] = 1'b0;
    idle(5);
    pc_in[2] = 1'b1;
    idle(5);
    pb_in = 8'h00;
    settle();
    chk("R9", "IBF and INTR on PC1/PC0", {6'b0, pc_out[1:0]}, 8'h03);
    host_read(2'd2, 8'h07, "R10");
    host_read(2'd1, 8'h4E, "R9");

    // R9 strobed output on port B
    host_write(2'd3, 8'h84);
    host_write(2'd3, 8'h05);
    host_write(2'd1, 8'h71);
    settle();
    chk("R9", "OBF low on PC1", {7'b0, pc_out[1]}, 8'h00);
    pc_in[2] = 1'b0;
    idle(5);
    settle();
    chk("R9", "OBF high after ACK", {7'b0, pc_out[1]}, 8'h01);
    pc_in[2] = 1'b1;
    idle(5);
    settle();
    chk("R9", "INTR on PC0", {7'b0, pc_out[0]}, 8'h01);
    host_write(2'd3, 8'h84);
    host_read(2'd2, 8'h02, "R4");

    idle(3);
    if (q_exp.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", q_exp.size());
    end
    finish_run();
  end
endmodule